// File: doc/BRIEF.md
# Graceful System Reset Controller

This block converts a raw, active-low system-reset button into a platform reset pulse of fixed width. It first synchronises the button to the core clock. It then requires the level to stay unchanged for a full debounce interval. When a debounced press is recognised, the block checks a flag that reports whether the SMBus is idle. If the bus is idle, the reset pulse starts at once. If the bus is busy, the block defers the reset until the bus goes quiet, but only up to a bounded timeout. After the timeout it forces the reset anyway.

All intervals are counted in periods of a single-cycle `tick_i` strobe, nominally 1 ms. The pulse has a minimum width and ends by itself, even if the button is still held. When the pulse ends, the controller locks out further presses. It re-arms only when three conditions hold together: the debounced button reads released, the system reports full S0, and platform reset is no longer asserted. A configuration bit, captured when the press is recognised, selects the output. When set, the pulse is raised on `pwrcyc_req_o` (a full power-cycle request) and `sys_rst_o` stays low. When clear, the pulse is raised on `sys_rst_o`.

Top module: `sysrst_graceful`

## Requirements
- R1: After `rst_n` is released, `sys_rst_o` and `pwrcyc_req_o` are both 0 and the controller is idle, with the button treated as released.
- R2: A change of the synchronised button level is accepted only after it has held for `DEBOUNCE_TICKS` consecutive ticks (default 16). A reversion before then restarts the count and produces no reset.
- R3: If `smb_idle_i` is 1 in the cycle a debounced press is seen while idle, the pulse output goes to 1 on the next clock edge.
- R4: If the bus is busy at that moment, the controller waits. The pulse starts on the clock edge after the first cycle in which `smb_idle_i` is 1.
- R5: If `smb_idle_i` stays 0 for `WAIT_TICKS` ticks (default 25) of waiting, the pulse starts on the edge after the last of those ticks.
- R6: Once started, the pulse stays high until `PULSE_TICKS` ticks (default 6) have occurred during it, whatever the button does. With a 1 ms tick, the width lies between 5 and 6 ms.
- R7: After a pulse, no new pulse can start until the debounced button is released, `full_s0_i` is 1 and `plat_rst_i` is 0 in the same cycle. Presses made before that have no effect.
- R8: `pwrcyc_cfg_i` is sampled when the press is recognised. With 1, the pulse appears on `pwrcyc_req_o` only. With 0, it appears on `sys_rst_o` only. The two outputs are never high together, and a change of the bit during a pulse does not alter it.
- R9: The button passes through `SYNC_STAGES` flip-flops (default 2) before the debounce logic. The press-to-pulse latency is therefore `SYNC_STAGES` cycles longer than the debounce time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle time-base strobe (one per ms nominal) |
| btn_n_i | input | 1 | Raw active-low reset button, asynchronous |
| smb_idle_i | input | 1 | 1 when no SMBus transaction is in progress |
| full_s0_i | input | 1 | 1 when the system is fully in working state S0 |
| plat_rst_i | input | 1 | 1 while platform reset is asserted |
| pwrcyc_cfg_i | input | 1 | Selects full power-cycle request instead of plain reset |
| sys_rst_o | output | 1 | Plain reset pulse, active high |
| pwrcyc_req_o | output | 1 | Full power-cycle request pulse, active high |

## Verification
The assertions assume that `tick_i` is a one-cycle strobe and that `smb_idle_i`, `full_s0_i` and `plat_rst_i` are synchronous to `clk`. They do not assume the button is synchronous. Only `btn_n_i` enters through the synchroniser. The stimulus drives every input on the falling edge and generates the tick from a free-running divider, so these conditions always hold. The button waveforms include glitches shorter than the debounce interval, a hold that lasts longer than the pulse, and presses made during lockout.

// File: rtl/sgr_pkg.sv
package sgr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_PULSE = 2'd2,
      ST_LOCK  = 2'd3
   } sgr_state_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      int unsigned w;
      w = 1;
      while ((1 << w) <= limit) w++;
      return w;
   endfunction

endpackage

// File: rtl/sgr_sync.sv
module sgr_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
            else        chain_q <= {chain_q[STAGES-2+1-1 -: STAGES-1+1-1 > 0 ? STAGES-1 : 1], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sgr_debounce.sv
module sgr_debounce #(
   parameter int unsigned TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic level_i,
   output logic level_o
);
   import sgr_pkg::*;

   localparam int unsigned CW = cnt_width(TICKS);
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic          stable_q;
   logic [CW-1:0] run_q;

   generate
      if (TICKS < 1) begin : g_bad
         $error("sgr_debounce: TICKS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stable_q <= 1'b0;
         run_q    <= '0;
      end else if (level_i == stable_q) begin
         run_q <= '0;
      end else if (tick_i) begin
         if (run_q == LAST) begin
            stable_q <= level_i;
            run_q    <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign level_o = stable_q;

endmodule

// File: rtl/sgr_fsm.sv
module sgr_fsm #(
   parameter int unsigned WAIT_TICKS  = 25,
   parameter int unsigned PULSE_TICKS = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic                press_i,
   input  logic                smb_idle_i,
   input  logic                full_s0_i,
   input  logic                plat_rst_i,
   input  logic                cfg_i,
   output sgr_pkg::sgr_state_e state_o,
   output logic                sys_rst_o,
   output logic                pwrcyc_o
);
   import sgr_pkg::*;

   localparam int unsigned MAXT = (WAIT_TICKS > PULSE_TICKS) ? WAIT_TICKS : PULSE_TICKS;
   localparam int unsigned CW   = cnt_width(MAXT);
   localparam logic [CW-1:0] WAIT_LAST  = CW'(WAIT_TICKS - 1);
   localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_TICKS - 1);

   generate
      if (WAIT_TICKS < 1) begin : g_bad_wait
         $error("sgr_fsm: WAIT_TICKS must be at least 1");
      end
      if (PULSE_TICKS < 1) begin : g_bad_pulse
         $error("sgr_fsm: PULSE_TICKS must be at least 1");
      end
   endgenerate

   sgr_state_e    st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          sel_q, sel_d;
   logic          rearm_ok;

   assign rearm_ok = !press_i && full_s0_i && !plat_rst_i;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      sel_d = sel_q;
      unique case (st_q)
         ST_IDLE: begin
            if (press_i) begin
               sel_d = cfg_i;
               cnt_d = '0;
               st_d  = smb_idle_i ? ST_PULSE : ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (smb_idle_i) begin
               st_d  = ST_PULSE;
               cnt_d = '0;
            end else if (tick_i) begin
               if (cnt_q == WAIT_LAST) begin
                  st_d  = ST_PULSE;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         ST_PULSE: begin
            if (tick_i) begin
               if (cnt_q == PULSE_LAST) begin
                  st_d  = ST_LOCK;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         ST_LOCK: begin
            if (rearm_ok) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         sel_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         sel_q <= sel_d;
      end
   end

   assign state_o   = st_q;
   assign sys_rst_o = (st_q == ST_PULSE) && !sel_q;
   assign pwrcyc_o  = (st_q == ST_PULSE) &&  sel_q;

endmodule

// File: rtl/sysrst_graceful.sv
module sysrst_graceful #(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned DEBOUNCE_TICKS = 16,
   parameter int unsigned WAIT_TICKS     = 25,
   parameter int unsigned PULSE_TICKS    = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic btn_n_i,
   input  logic smb_idle_i,
   input  logic full_s0_i,
   input  logic plat_rst_i,
   input  logic pwrcyc_cfg_i,
   output logic sys_rst_o,
   output logic pwrcyc_req_o
);
   import sgr_pkg::*;

   logic       btn_n_sync;
   logic       btn_press_raw;
   logic       deb_press;
   sgr_state_e ctl_state;

   sgr_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (btn_n_i),
      .q_o   (btn_n_sync)
   );

   assign btn_press_raw = ~btn_n_sync;

   sgr_debounce #(
      .TICKS (DEBOUNCE_TICKS)
   ) u_deb (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .level_i (btn_press_raw),
      .level_o (deb_press)
   );

   sgr_fsm #(
      .WAIT_TICKS  (WAIT_TICKS),
      .PULSE_TICKS (PULSE_TICKS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .press_i    (deb_press),
      .smb_idle_i (smb_idle_i),
      .full_s0_i  (full_s0_i),
      .plat_rst_i (plat_rst_i),
      .cfg_i      (pwrcyc_cfg_i),
      .state_o    (ctl_state),
      .sys_rst_o  (sys_rst_o),
      .pwrcyc_o   (pwrcyc_req_o)
   );

endmodule

// File: rtl/sysrst_graceful_chk.sv
module sysrst_graceful_chk #(
   parameter int unsigned PULSE_TICKS = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick_i,
   input logic                smb_idle_i,
   input logic                full_s0_i,
   input logic                plat_rst_i,
   input logic                pwrcyc_cfg_i,
   input logic                deb_press,
   input sgr_pkg::sgr_state_e st,
   input logic                sys_rst_o,
   input logic                pwrcyc_req_o
);
   import sgr_pkg::*;

   int unsigned pulse_ticks;
   logic        unused_cfg;
   assign unused_cfg = pwrcyc_cfg_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         pulse_ticks <= 0;
      else if (st != ST_PULSE)            pulse_ticks <= 0;
      else if (tick_i)                    pulse_ticks <= pulse_ticks + 1;
   end

   a_r3_idle_bus_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && deb_press && smb_idle_i) |=> (sys_rst_o || pwrcyc_req_o));

   a_r4_wait_ends_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && smb_idle_i) |=> (sys_rst_o || pwrcyc_req_o));

   a_r5_no_early_force: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !smb_idle_i && !tick_i) |=> (st == ST_WAIT));

   a_r6_pulse_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PULSE && !tick_i) |=> (sys_rst_o || pwrcyc_req_o));

   a_r6_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_ticks <= PULSE_TICKS);

   a_r7_lockout_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOCK && (deb_press || !full_s0_i || plat_rst_i)) |=> (st == ST_LOCK));

   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sys_rst_o, pwrcyc_req_o}));

   a_r8_kind_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PULSE && $past(st == ST_PULSE)) |-> $stable({sys_rst_o, pwrcyc_req_o}));

endmodule

bind sysrst_graceful sysrst_graceful_chk #(
   .PULSE_TICKS (PULSE_TICKS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_i       (tick_i),
   .smb_idle_i   (smb_idle_i),
   .full_s0_i    (full_s0_i),
   .plat_rst_i   (plat_rst_i),
   .pwrcyc_cfg_i (pwrcyc_cfg_i),
   .deb_press    (deb_press),
   .st           (ctl_state),
   .sys_rst_o    (sys_rst_o),
   .pwrcyc_req_o (pwrcyc_req_o)
);

// File: tb/tb_sysrst_graceful.sv
`timescale 1ns/1ps
module tb_sysrst_graceful;

   localparam int SY  = 2;
   localparam int DEB = 16;
   localparam int WT  = 25;
   localparam int PT  = 6;
   localparam int TC  = 8;     // clock cycles per scaled 1 ms tick

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 1'b0;
   logic btn_n_i = 1'b1;
   logic smb_idle_i = 1'b1;
   logic full_s0_i = 1'b1;
   logic plat_rst_i = 1'b0;
   logic pwrcyc_cfg_i = 1'b0;
   logic sys_rst_o, pwrcyc_req_o;

   always #2.5 clk = ~clk;

   sysrst_graceful #(
      .SYNC_STAGES(SY), .DEBOUNCE_TICKS(DEB), .WAIT_TICKS(WT), .PULSE_TICKS(PT)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .btn_n_i(btn_n_i),
      .smb_idle_i(smb_idle_i), .full_s0_i(full_s0_i), .plat_rst_i(plat_rst_i),
      .pwrcyc_cfg_i(pwrcyc_cfg_i), .sys_rst_o(sys_rst_o), .pwrcyc_req_o(pwrcyc_req_o)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   string cur_req = "R1";

   // tick divider
   int tdiv = 0;
   always @(negedge clk) begin
      tdiv   = (tdiv + 1) % TC;
      tick_i <= (tdiv == 0);
   end

   always @(posedge clk) cyc <= cyc + 1;

   // behavioural reference model
   bit m_pipe[$];        // R9: synchroniser delay line
   bit m_deb;
   int m_run;
   int m_mode;           // 0 idle, 1 waiting, 2 pulsing, 3 locked
   int m_cnt;
   bit m_kind;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pipe = {};
         for (int i = 0; i < SY; i++) m_pipe.push_back(1'b1);
         m_deb = 0; m_run = 0; m_mode = 0; m_cnt = 0; m_kind = 0;
      end else begin
         bit raw_press;
         raw_press = !m_pipe[0];
         case (m_mode)
            0: if (m_deb) begin
                  m_kind = pwrcyc_cfg_i; m_cnt = 0;
                  m_mode = smb_idle_i ? 2 : 1;
               end
            1: if (smb_idle_i) begin m_mode = 2; m_cnt = 0; end
               else if (tick_i) begin
                  m_cnt++;
                  if (m_cnt == WT) begin m_mode = 2; m_cnt = 0; end
               end
            2: if (tick_i) begin
                  m_cnt++;
                  if (m_cnt == PT) begin m_mode = 3; m_cnt = 0; end
               end
            default: if (!m_deb && full_s0_i && !plat_rst_i) m_mode = 0;
         endcase
         if (raw_press == m_deb) m_run = 0;
         else if (tick_i) begin
            m_run++;
            if (m_run == DEB) begin m_deb = raw_press; m_run = 0; end
         end
         void'(m_pipe.pop_front());
         m_pipe.push_back(btn_n_i);
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // per-cycle comparison and pulse monitor
   int rst_pulses = 0, pwr_pulses = 0;
   int width = 0, last_width = 0, rise_cyc = 0;
   bit prev_any = 0;
   always @(negedge clk) begin
      bit e_rst, e_pwr, any;
      e_rst = (m_mode == 2) && !m_kind;
      e_pwr = (m_mode == 2) &&  m_kind;
      if (rst_n) begin
         chk(sys_rst_o == e_rst, cur_req, sys_rst_o, e_rst);
         chk(pwrcyc_req_o == e_pwr, cur_req, pwrcyc_req_o, e_pwr);
      end
      any = sys_rst_o | pwrcyc_req_o;
      if (any && !prev_any) begin
         rise_cyc = cyc; width = 0;
         if (sys_rst_o) rst_pulses++; else pwr_pulses++;
      end
      if (any) width++;
      if (!any && prev_any) last_width = width;
      prev_any = any;
   end

   task automatic wt(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      summary();
   end

   initial begin
      int r0, p0, t0;
      wt(5);
      rst_n = 1'b1;
      wt(2);
      cur_req = "R1";
      chk(sys_rst_o == 0, "R1", sys_rst_o, 0);
      chk(pwrcyc_req_o == 0, "R1", pwrcyc_req_o, 0);
      wt(40);

      // R3 idle bus, R9 latency, R6 width
      cur_req = "R3";
      t0 = cyc; btn_n_i = 0;
      wt(200);
      chk(rst_pulses == 1, "R3", rst_pulses, 1);
      chk((rise_cyc - t0) >= SY + (DEB-1)*TC && (rise_cyc - t0) <= SY + DEB*TC + 2,
          "R9", rise_cyc - t0, SY + DEB*TC);
      chk(last_width > (PT-1)*TC && last_width <= PT*TC, "R6", last_width, PT*TC);
      btn_n_i = 1; wt(200);

      // R2 glitches shorter than debounce
      cur_req = "R2";
      r0 = rst_pulses;
      btn_n_i = 0; wt((DEB-4)*TC); btn_n_i = 1; wt(3);
      btn_n_i = 0; wt((DEB-4)*TC); btn_n_i = 1; wt(300);
      chk(rst_pulses == r0, "R2", rst_pulses, r0);

      // R4 busy bus then idle
      cur_req = "R4";
      smb_idle_i = 0; btn_n_i = 0;
      wt(250);
      chk(rst_pulses == r0, "R4", rst_pulses, r0);
      smb_idle_i = 1; wt(2);
      chk(sys_rst_o == 1, "R4", sys_rst_o, 1);
      btn_n_i = 1; wt(300);

      // R5 timeout with bus stuck busy; button held through pulse (R6)
      cur_req = "R5";
      r0 = rst_pulses;
      smb_idle_i = 0; btn_n_i = 0;
      wt(250);
      chk(rst_pulses == r0, "R5", rst_pulses, r0);
      wt(200);
      chk(rst_pulses == r0 + 1, "R5", rst_pulses, r0 + 1);
      chk(last_width > (PT-1)*TC && last_width <= PT*TC, "R6", last_width, PT*TC);
      wt(300);
      chk(rst_pulses == r0 + 1, "R7", rst_pulses, r0 + 1);
      btn_n_i = 1; smb_idle_i = 1; wt(300);

      // R7 lockout: no S0, then platform reset active
      cur_req = "R7";
      r0 = rst_pulses;
      btn_n_i = 0; wt(200); btn_n_i = 1;
      full_s0_i = 0; wt(200);
      btn_n_i = 0; wt(200);
      chk(rst_pulses == r0 + 1, "R7", rst_pulses, r0 + 1);
      btn_n_i = 1; full_s0_i = 1; plat_rst_i = 1; wt(200);
      btn_n_i = 0; wt(200);
      chk(rst_pulses == r0 + 1, "R7", rst_pulses, r0 + 1);
      btn_n_i = 1; plat_rst_i = 0; wt(200);
      btn_n_i = 0; wt(200);
      chk(rst_pulses == r0 + 2, "R7", rst_pulses, r0 + 2);
      btn_n_i = 1; wt(300);

      // R8 power-cycle selection, bit changed mid-pulse
      cur_req = "R8";
      r0 = rst_pulses; p0 = pwr_pulses;
      pwrcyc_cfg_i = 1; btn_n_i = 0;
      wait (pwrcyc_req_o == 1'b1);
      @(negedge clk);
      pwrcyc_cfg_i = 0;
      wt(200);
      chk(pwr_pulses == p0 + 1, "R8", pwr_pulses, p0 + 1);
      chk(rst_pulses == r0, "R8", rst_pulses, r0);
      chk(last_width > (PT-1)*TC && last_width <= PT*TC, "R8", last_width, PT*TC);
      btn_n_i = 1; wt(300);

      summary();
   end

endmodule